// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Receiver

This block turns an asynchronous NRZ bit stream into words. A free-running tick at sixteen times the bit rate paces it. The line passes through a flip-flop synchroniser. A falling edge in idle arms a frame. Each bit's level is then decided by a two-out-of-three vote over three ticks in the middle of the bit. A frame has one low start bit, eight data bits sent least significant bit first, an optional ninth bit, and one high stop bit.

Each finished word goes into a two-entry receive queue together with its ninth bit and its framing status. The host sees the head entry and removes it with a one-cycle pop. The block raises an overrun flag when a word arrives with the queue full. It latches that flag until reception is switched off. In nine-bit mode an address filter can drop every word whose ninth bit is clear.

Top module: `async_rx_vote`

## Requirements
- R1: After reset `data_avail`, `overrun` and `rd_frame_err` are 0.
- R2: With `nine_bit_en`=0, a frame of start, eight data bits least significant bit first, and stop yields `rd_data` equal to the sent byte and `rd_bit8`=0.
- R3: With `nine_bit_en`=1, a ninth bit follows data bit 7. Its value appears on `rd_bit8` for that word.
- R4: Each bit level is the majority of the line on the 7th, 8th and 9th tick of that bit. A level inverted for one tick period at the 8th tick does not change the received word.
- R5: A low pulse that has ended before the 7th tick of a start bit is ignored. No word is delivered for it.
- R6: A stop bit sampled low sets `rd_frame_err`=1 for that word only. The following good word shows 0.
- R7: The queue holds two words in arrival order. `rd_data`, `rd_bit8` and `rd_frame_err` belong to the head word. A pulse on `rd_pop` advances them to the next word.
- R8: `data_avail` rises once a word has been queued. It falls when the last queued word is popped.
- R9: A word whose stop bit completes while two words are queued is discarded and sets `overrun`. While `overrun`=1 no further word is queued, even after pops.
- R10: While `rx_enable`=0 the receiver is idle, the queue is empty, `overrun`=0, and line activity delivers nothing. Raising `rx_enable` again restores reception.
- R11: With `nine_bit_en`=1 and `addr_filter_en`=1, a word is queued only if its ninth bit is 1. With `addr_filter_en`=0, words with ninth bit 0 are queued as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rx_enable | input | 1 | Continuous receive enable; low clears and holds the receiver |
| nine_bit_en | input | 1 | 1 = frames carry a ninth data bit |
| addr_filter_en | input | 1 | 1 = in nine-bit mode keep only words whose ninth bit is 1 |
| rd_pop | input | 1 | Remove the head word (ignored when empty) |
| rd_data | output | 8 | Head word data |
| rd_bit8 | output | 1 | Head word ninth bit |
| rd_frame_err | output | 1 | Head word framing error |
| data_avail | output | 1 | Queue not empty |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench aims a one-tick inversion at the middle sample of a data bit. A design that samples once, or votes on the wrong ticks, would flip that bit. It sends a start pulse too short to reach mid-bit. A receiver that does not re-check the start level would then produce a phantom word. It fills the queue and keeps sending after pops and after a further frame. A design that clears overrun on a read, or keeps loading past it, would show extra words. It also interleaves bad-stop and good-stop words and filtered and unfiltered ninth-bit words. Status that is not kept per entry, or a filter that ignores the mode bits, would show up as wrong head values.

// File: rtl/rxmv_pkg.sv
package rxmv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_STOP
   } rx_state_e;

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/rxmv_sync.sv
module rxmv_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   initial assert (STAGES >= 2) else $error("rxmv_sync: STAGES must be at least 2");

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxmv_bit_engine.sv
module rxmv_bit_engine
   import rxmv_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tick,
   input  logic              rx_s,
   input  logic              nine_bit,
   output logic              word_valid,
   output logic [DATA_W-1:0] word_data,
   output logic              word_b8,
   output logic              word_ferr
);
   localparam int PH_W  = $clog2(OSR);
   localparam int IDX_W = $clog2(DATA_W + 1);
   localparam logic [PH_W-1:0]  PH_S1   = PH_W'(OSR/2 - 2);
   localparam logic [PH_W-1:0]  PH_S2   = PH_W'(OSR/2 - 1);
   localparam logic [PH_W-1:0]  PH_S3   = PH_W'(OSR/2);
   localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OSR - 1);

   initial assert (OSR >= 8 && (OSR & (OSR - 1)) == 0)
      else $error("rxmv_bit_engine: OSR must be a power of two of at least 8");
   initial assert (DATA_W >= 2) else $error("rxmv_bit_engine: DATA_W too small");

   rx_state_e          state;
   logic [PH_W-1:0]    ph;
   logic [IDX_W-1:0]   idx;
   logic [DATA_W:0]    sr;
   logic               smp_a, smp_b, last_lvl;
   logic               level;
   logic [IDX_W-1:0]   idx_end;

   assign level   = vote3(smp_a, smp_b, rx_s);
   assign idx_end = nine_bit ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         ph         <= '0;
         idx        <= '0;
         sr         <= '0;
         smp_a      <= 1'b1;
         smp_b      <= 1'b1;
         last_lvl   <= 1'b1;
         word_valid <= 1'b0;
         word_data  <= '0;
         word_b8    <= 1'b0;
         word_ferr  <= 1'b0;
      end else if (!enable) begin
         state      <= ST_IDLE;
         ph         <= '0;
         idx        <= '0;
         last_lvl   <= rx_s;
         word_valid <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         if (tick) begin
            if (state == ST_IDLE) begin
               last_lvl <= rx_s;
               if (last_lvl && !rx_s) begin
                  state <= ST_START;
                  ph    <= '0;
               end
            end else begin
               ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
               if (ph == PH_S1) smp_a <= rx_s;
               if (ph == PH_S2) smp_b <= rx_s;
               if (ph == PH_S3) begin
                  case (state)
                     ST_START: if (level) begin
                        state    <= ST_IDLE;
                        last_lvl <= rx_s;
                     end
                     ST_DATA: sr[idx] <= level;
                     ST_STOP: begin
                        word_valid <= 1'b1;
                        word_data  <= sr[DATA_W-1:0];
                        word_b8    <= nine_bit & sr[DATA_W];
                        word_ferr  <= ~level;
                        state      <= ST_IDLE;
                        last_lvl   <= rx_s;
                     end
                     default: ;
                  endcase
               end
               if (ph == PH_LAST) begin
                  if (state == ST_START) begin
                     state <= ST_DATA;
                     idx   <= '0;
                  end else if (state == ST_DATA) begin
                     if (idx == idx_end) state <= ST_STOP;
                     else                idx   <= idx + 1'b1;
                  end
               end
            end
         end
      end
   end

   // R2
   stop_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> (state == ST_IDLE));
   // R10
   disabled_is_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (state == ST_IDLE && !word_valid));
endmodule

// File: rtl/rxmv_fifo.sv
module rxmv_fifo #(
   parameter int W     = 10,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   initial assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
      else $error("rxmv_fifo: DEPTH must be a power of two of at least 2");

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wr_ptr] <= din;
   end

   assign dout  = mem[rd_ptr];
   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));

   // R9
   fifo_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R7
   fifo_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/async_rx_vote.sv
module async_rx_vote #(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int DEPTH       = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit ADDR_FILTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rx_in,
   input  logic              rx_enable,
   input  logic              nine_bit_en,
   input  logic              addr_filter_en,
   input  logic              rd_pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_bit8,
   output logic              rd_frame_err,
   output logic              data_avail,
   output logic              overrun
);
   localparam int ENTRY_W = DATA_W + 2;

   logic              rx_s;
   logic              w_valid, w_b8, w_ferr;
   logic [DATA_W-1:0] w_data;
   logic              accept, push, pop, q_empty, q_full;
   logic [ENTRY_W-1:0] q_out;

   rxmv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_s)
   );

   rxmv_bit_engine #(.DATA_W(DATA_W), .OSR(OSR)) u_engine (
      .clk(clk), .rst_n(rst_n), .enable(rx_enable), .tick(os_tick),
      .rx_s(rx_s), .nine_bit(nine_bit_en),
      .word_valid(w_valid), .word_data(w_data), .word_b8(w_b8), .word_ferr(w_ferr)
   );

   generate
      if (ADDR_FILTER) begin : g_filter
         assign accept = !(nine_bit_en && addr_filter_en) || w_b8;
         // R11
         filter_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (w_valid && nine_bit_en && addr_filter_en && !w_b8) |=> $stable(data_avail) || !rx_enable || $fell(data_avail));
      end else begin : g_nofilter
         assign accept = 1'b1;
      end
   endgenerate

   assign push = rx_enable && w_valid && accept && !overrun && !q_full;
   assign pop  = rd_pop && !q_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       overrun <= 1'b0;
      else if (!rx_enable)                              overrun <= 1'b0;
      else if (w_valid && accept && !overrun && q_full) overrun <= 1'b1;
   end

   rxmv_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(!rx_enable),
      .push(push), .din({w_ferr, w_b8, w_data}),
      .pop(pop), .dout(q_out), .empty(q_empty), .full(q_full)
   );

   assign rd_data      = q_out[DATA_W-1:0];
   assign rd_bit8      = q_empty ? 1'b0 : q_out[DATA_W];
   assign rd_frame_err = q_empty ? 1'b0 : q_out[DATA_W+1];
   assign data_avail   = !q_empty;

   // R9
   overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && rx_enable) |=> overrun);
   // R10
   disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enable |=> (!overrun && !data_avail));
   // R8
   avail_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && rx_enable) |=> data_avail);
endmodule

// File: tb/async_rx_vote_test.sv
`timescale 1ns/1ps
module async_rx_vote_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       rx_in = 1'b1;
   logic       rx_enable = 1'b0;
   logic       nine_bit_en = 1'b0;
   logic       addr_filter_en = 1'b0;
   logic       rd_pop = 1'b0;
   logic [7:0] rd_data;
   logic       rd_bit8, rd_frame_err, data_avail, overrun;

   int total = 0;
   int bad = 0;
   int div = 0;
   bit auto_rd = 1'b0;
   bit finished = 1'b0;
   logic [9:0] exp_q[$];
   string      req_q[$];

   always #2 clk = ~clk;

   async_rx_vote uut (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
      .rx_enable(rx_enable), .nine_bit_en(nine_bit_en), .addr_filter_en(addr_filter_en),
      .rd_pop(rd_pop), .rd_data(rd_data), .rd_bit8(rd_bit8),
      .rd_frame_err(rd_frame_err), .data_avail(data_avail), .overrun(overrun)
   );

   always @(negedge clk) begin
      div = (div + 1) % 4;
      os_tick = (div == 0);
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic next_tick();
      @(posedge clk);
      while (!os_tick) @(posedge clk);
   endtask

   task automatic send_level(input logic lvl, input bit glitch);
      for (int p = 0; p < 16; p++) begin
         @(negedge clk);
         rx_in = (glitch && p == 7) ? ~lvl : lvl;
         next_tick();
      end
   endtask

   task automatic idle_ticks(input int n);
      for (int p = 0; p < n; p++) begin
         @(negedge clk);
         rx_in = 1'b1;
         next_tick();
      end
   endtask

   task automatic send_frame(input logic [7:0] d, input logic b8, input bit nine,
                             input logic stop_lvl, input int glitch_bit);
      send_level(1'b0, 1'b0);
      for (int i = 0; i < 8; i++) send_level(d[i], glitch_bit == i);
      if (nine) send_level(b8, 1'b0);
      send_level(stop_lvl, 1'b0);
      idle_ticks(4);
   endtask

   task automatic expect_word(input logic [7:0] d, input logic b8, input logic fe, input string req);
      exp_q.push_back({fe, b8, d});
      req_q.push_back(req);
   endtask

   task automatic drain(input string req);
      repeat (20) @(negedge clk);
      check(req, "expected words still pending", exp_q.size(), 0);
   endtask

   task automatic pop_once();
      @(negedge clk);
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
   endtask

   task automatic head_is(input string req, input logic [7:0] d, input logic b8, input logic fe);
      check(req, "data_avail", data_avail, 1);
      check(req, "head word", {rd_frame_err, rd_bit8, rd_data}, {fe, b8, d});
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (auto_rd) begin
            if (rd_pop) rd_pop = 1'b0;
            else if (data_avail) begin
               if (exp_q.size() == 0) begin
                  total++;
                  bad++;
                  $display("FAIL R5/R11 unexpected word: actual=%0h expected=none",
                           {rd_frame_err, rd_bit8, rd_data});
               end else begin
                  logic [9:0] e;
                  string r;
                  e = exp_q.pop_front();
                  r = req_q.pop_front();
                  check(r, "received word", {rd_frame_err, rd_bit8, rd_data}, e);
               end
               rd_pop = 1'b1;
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1 reset state
      check("R1", "data_avail", data_avail, 0);
      check("R1", "overrun", overrun, 0);
      check("R1", "rd_frame_err", rd_frame_err, 0);
      rst_n = 1'b1;
      @(negedge clk);
      rx_enable = 1'b1;
      idle_ticks(4);

      auto_rd = 1'b1;
      // R2 plain eight-bit words
      expect_word(8'hA5, 0, 0, "R2"); send_frame(8'hA5, 0, 0, 1, -1);
      expect_word(8'h3C, 0, 0, "R2"); send_frame(8'h3C, 0, 0, 1, -1);
      expect_word(8'h00, 0, 0, "R2"); send_frame(8'h00, 0, 0, 1, -1);
      expect_word(8'hFF, 0, 0, "R2"); send_frame(8'hFF, 0, 0, 1, -1);
      drain("R2");
      // R4 single-tick inversion at the middle sample
      expect_word(8'h5A, 0, 0, "R4"); send_frame(8'h5A, 0, 0, 1, 2);
      expect_word(8'h81, 0, 0, "R4"); send_frame(8'h81, 0, 0, 1, 7);
      drain("R4");
      // R5 short start pulse
      for (int p = 0; p < 4; p++) begin @(negedge clk); rx_in = 1'b0; next_tick(); end
      idle_ticks(40);
      drain("R5");
      // R6 framing error then recovery
      expect_word(8'h81, 0, 1, "R6"); send_frame(8'h81, 0, 0, 0, -1);
      expect_word(8'h42, 0, 0, "R6"); send_frame(8'h42, 0, 0, 1, -1);
      drain("R6");
      // R3 nine-bit frames
      nine_bit_en = 1'b1;
      expect_word(8'h17, 1, 0, "R3"); send_frame(8'h17, 1, 1, 1, -1);
      expect_word(8'h28, 0, 0, "R3"); send_frame(8'h28, 0, 1, 1, -1);
      drain("R3");
      // R11 address filter
      addr_filter_en = 1'b1;
      send_frame(8'h33, 0, 1, 1, -1);
      expect_word(8'h44, 1, 0, "R11"); send_frame(8'h44, 1, 1, 1, -1);
      drain("R11");
      addr_filter_en = 1'b0;
      expect_word(8'h55, 0, 0, "R11"); send_frame(8'h55, 0, 1, 1, -1);
      drain("R11");
      nine_bit_en = 1'b0;

      auto_rd = 1'b0;
      repeat (3) @(negedge clk);
      // R7 / R8 ordering and head status
      send_frame(8'h11, 0, 0, 0, -1);
      send_frame(8'h22, 0, 0, 1, -1);
      head_is("R7", 8'h11, 0, 1);
      pop_once();
      head_is("R7", 8'h22, 0, 0);
      pop_once();
      check("R8", "data_avail after last pop", data_avail, 0);

      // R9 overrun
      send_frame(8'h31, 0, 0, 1, -1);
      send_frame(8'h32, 0, 0, 1, -1);
      check("R9", "overrun with two queued", overrun, 0);
      send_frame(8'h33, 0, 0, 1, -1);
      check("R9", "overrun after third word", overrun, 1);
      head_is("R9", 8'h31, 0, 0);
      send_frame(8'h34, 0, 0, 1, -1);
      pop_once();
      head_is("R9", 8'h32, 0, 0);
      pop_once();
      check("R9", "data_avail after draining", data_avail, 0);
      send_frame(8'h35, 0, 0, 1, -1);
      check("R9", "word loaded during overrun", data_avail, 0);
      check("R9", "overrun sticky", overrun, 1);

      // R10 disable clears and blocks
      @(negedge clk); rx_enable = 1'b0;
      repeat (2) @(negedge clk);
      check("R10", "overrun after disable", overrun, 0);
      @(negedge clk); rx_enable = 1'b1;
      send_frame(8'h61, 0, 0, 1, -1);
      check("R10", "word before flush", data_avail, 1);
      @(negedge clk); rx_enable = 1'b0;
      repeat (2) @(negedge clk);
      check("R10", "queue flushed", data_avail, 0);
      send_frame(8'h66, 0, 0, 1, -1);
      check("R10", "word while disabled", data_avail, 0);
      @(negedge clk); rx_enable = 1'b1;
      idle_ticks(2);
      send_frame(8'h77, 0, 0, 1, -1);
      head_is("R10", 8'h77, 0, 0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule